// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

The block is a register of parameterised width (four bits by default). On each rising clock edge it does one of four things, chosen by a 2-bit mode input. It can keep its value, shift toward the high bit, shift toward the low bit, or take a full word from its parallel input. Each bit position has its own four-way selector, and that selector feeds a D flip-flop.

The register has two serial inputs, one for each shift direction. The direction that moves data toward the high bit (called "right" here) takes its new bit at bit 0. The direction that moves data toward bit 0 (called "left") takes its new bit at the top bit. The register contents are always visible on the parallel output.

An active-low clear empties the register at once, without waiting for a clock edge. Rotation needs no extra logic: wire the top output back to the right serial input, or wire bit 0 back to the left serial input.

Top module: `univ_shreg`

## Requirements
- R1: When mode is 2'b00, a rising edge leaves `q` unchanged, whatever the serial and parallel inputs are.
- R2: When mode is 2'b11, a rising edge copies `par_d` into `q`, with bit i going to bit i.
- R3: When mode is 2'b01 (shift right), a rising edge makes the next `q` equal to {q[W-2:0], ser_r}. The serial right input enters at bit 0.
- R4: When mode is 2'b10 (shift left), a rising edge makes the next `q` equal to {ser_l, q[W-1:1]}. The serial left input enters at bit W-1.
- R5: Driving `clr_n` low forces `q` to zero at once, before any clock edge.
- R6: While `clr_n` is low, rising edges leave `q` at zero in every mode.
- R7: After `clr_n` goes high, the first rising edge acts on the selected mode as normal.
- R8: With `ser_r` tied to q[W-1] and mode 2'b01, `q` rotates by one place per edge and is back at its starting value after W edges.
- R9: With `ser_l` tied to q[0] and mode 2'b10, `q` rotates the other way and is back at its starting value after W edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | 00 hold, 01 shift right, 10 shift left, 11 parallel load |
| ser_r | input | 1 | Serial bit entering bit 0 during a right shift |
| ser_l | input | 1 | Serial bit entering bit W-1 during a left shift |
| par_d | input | W | Parallel load word |
| q | output | W | Register contents |

## Verification
The hold, load and shift results each appear on `q` one rising edge after the inputs that request them. The bench therefore changes its inputs on the falling edge and reads `q` 1 ns after the next rising edge. The clear is the exception, because it acts without a clock. Its check reads `q` 1 ns after `clr_n` falls, in the middle of a clock period, before any edge. The rotation checks read `q` after the first edge and again after the W-th edge, so they confirm both the direction of the rotation and that the value returns to where it started.

// File: rtl/usr_pkg.sv
package usr_pkg;
  typedef enum logic [1:0] {
    M_HOLD = 2'b00,
    M_SHR  = 2'b01,
    M_SHL  = 2'b10,
    M_LOAD = 2'b11
  } mode_e;
endpackage

// File: rtl/usr_mux4.sv
module usr_mux4 (
  input  usr_pkg::mode_e sel,
  input  logic           keep_i,
  input  logic           lo_i,
  input  logic           hi_i,
  input  logic           par_i,
  output logic           y_o
);
  always_comb begin
    unique case (sel)
      usr_pkg::M_HOLD: y_o = keep_i;
      usr_pkg::M_SHR:  y_o = lo_i;
      usr_pkg::M_SHL:  y_o = hi_i;
      default:         y_o = par_i;
    endcase
  end
endmodule

// File: rtl/usr_dff_clr.sv
module usr_dff_clr (
  input  logic clk,
  input  logic clr_n,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q_o <= 1'b0;
    else        q_o <= d_i;
  end
endmodule

// File: rtl/usr_cell.sv
module usr_cell (
  input  logic           clk,
  input  logic           clr_n,
  input  usr_pkg::mode_e sel,
  input  logic           lo_i,
  input  logic           hi_i,
  input  logic           par_i,
  output logic           q_o
);
  logic d_w;

  usr_mux4 mux_i (
    .sel(sel), .keep_i(q_o), .lo_i(lo_i), .hi_i(hi_i), .par_i(par_i), .y_o(d_w)
  );

  usr_dff_clr ff_i (
    .clk(clk), .clr_n(clr_n), .d_i(d_w), .q_o(q_o)
  );
endmodule

// File: rtl/univ_shreg.sv
module univ_shreg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [1:0]   mode,
  input  logic         ser_r,
  input  logic         ser_l,
  input  logic [W-1:0] par_d,
  output logic [W-1:0] q
);
  localparam int TOP = W - 1;

  usr_pkg::mode_e sel_w;
  assign sel_w = usr_pkg::mode_e'(mode);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic lo_w, hi_w;
    if (i == 0) begin : g_lo_end
      assign lo_w = ser_r;
    end else begin : g_lo_mid
      assign lo_w = q[i-1];
    end
    if (i == TOP) begin : g_hi_end
      assign hi_w = ser_l;
    end else begin : g_hi_mid
      assign hi_w = q[i+1];
    end
    usr_cell cell_i (
      .clk(clk), .clr_n(clr_n), .sel(sel_w),
      .lo_i(lo_w), .hi_i(hi_w), .par_i(par_d[i]), .q_o(q[i])
    );
  end

  // R1
  hold_keeps_chk: assert property (@(posedge clk) disable iff (!clr_n)
    mode == 2'b00 |=> $stable(q));
  // R2
  load_copy_chk: assert property (@(posedge clk) disable iff (!clr_n)
    mode == 2'b11 |=> q == $past(par_d));
  // R3
  shr_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
    mode == 2'b01 |=> q == {$past(q[W-2:0]), $past(ser_r)});
  // R4
  shl_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
    mode == 2'b10 |=> q == {$past(ser_l), $past(q[W-1:1])});
  // R6
  clear_zero_chk: assert property (@(posedge clk) !clr_n |-> q == '0);
endmodule

// File: tb/univ_shreg_tb_top.sv
module univ_shreg_tb_top;
  localparam int W = 4;
  localparam int NV = 12;
  // fields: mode[11:10] ser_r[9] ser_l[8] par_d[7:4] expected q[3:0]
  localparam logic [11:0] VEC [NV] = '{
    12'b11_0_0_1011_1011,
    12'b00_0_0_0000_1011,
    12'b01_0_0_0000_0110,
    12'b01_1_0_0000_1101,
    12'b10_0_0_0000_0110,
    12'b10_0_1_0000_1011,
    12'b00_1_1_0101_1011,
    12'b11_0_0_0101_0101,
    12'b01_1_0_0000_1011,
    12'b10_0_1_0000_1101,
    12'b11_0_0_0000_0000,
    12'b10_0_1_1111_1000
  };

  logic clk = 1'b0;
  logic clr_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic sr_drv = 1'b0, sl_drv = 1'b0, tie_r = 1'b0, tie_l = 1'b0;
  logic [W-1:0] par_d = '0;
  logic [W-1:0] q;
  logic ser_r, ser_l;
  int total = 0, bad = 0;
  bit done = 0;

  assign ser_r = tie_r ? q[W-1] : sr_drv;
  assign ser_l = tie_l ? q[0] : sl_drv;

  always #2 clk = ~clk;

  univ_shreg #(.W(W)) dut_i (
    .clk(clk), .clr_n(clr_n), .mode(mode), .ser_r(ser_r), .ser_l(ser_l),
    .par_d(par_d), .q(q)
  );

  task automatic check(input string req, input logic [W-1:0] exp);
    total++;
    if (q !== exp) begin
      bad++;
      $display("FAIL %s: q=%b expected=%b", req, q, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic sr, input logic sl,
                      input logic [W-1:0] pd);
    @(negedge clk);
    mode = m; sr_drv = sr; sl_drv = sl; par_d = pd;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1;
    check("R5 reset state", 4'b0000);
    repeat (2) @(posedge clk);
    #1;
    check("R6 held clear", 4'b0000);
    @(negedge clk);
    clr_n = 1'b1;
    // table walk: R1 hold, R2 load, R3 right, R4 left
    for (int k = 0; k < NV; k++) begin
      step(VEC[k][11:10], VEC[k][9], VEC[k][8], VEC[k][7:4]);
      case (VEC[k][11:10])
        2'b00:   check("R1 hold", VEC[k][3:0]);
        2'b01:   check("R3 shift right", VEC[k][3:0]);
        2'b10:   check("R4 shift left", VEC[k][3:0]);
        default: check("R2 load", VEC[k][3:0]);
      endcase
    end
    // R5 asynchronous clear, mid-cycle
    step(2'b11, 0, 0, 4'b1111);
    check("R2 load ones", 4'b1111);
    @(negedge clk);
    mode = 2'b00;
    #0.5;
    clr_n = 1'b0;
    #0.5;
    check("R5 immediate clear", 4'b0000);
    // R6 priority over load
    mode = 2'b11; par_d = 4'b1111;
    repeat (2) @(posedge clk);
    #1;
    check("R6 clear over load", 4'b0000);
    // R7 resume on first edge
    @(negedge clk);
    clr_n = 1'b1; par_d = 4'b1001;
    @(posedge clk);
    #1;
    check("R7 first edge after release", 4'b1001);
    // R8 rotate right
    step(2'b11, 0, 0, 4'b1011);
    @(negedge clk);
    tie_r = 1'b1; mode = 2'b01;
    @(posedge clk);
    #1;
    check("R8 rotate right one step", 4'b0111);
    repeat (3) @(posedge clk);
    #1;
    check("R8 rotate right full turn", 4'b1011);
    @(negedge clk);
    tie_r = 1'b0; mode = 2'b00;
    // R9 rotate left
    @(negedge clk);
    tie_l = 1'b1; mode = 2'b10;
    @(posedge clk);
    #1;
    check("R9 rotate left one step", 4'b1101);
    repeat (3) @(posedge clk);
    #1;
    check("R9 rotate left full turn", 4'b1011);
    @(negedge clk);
    tie_l = 1'b0; mode = 2'b00;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: q=%b expected=completion", q);
    finish_run();
  end
endmodule